// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Datapath

This block executes one stack operation at a time against a small word-addressed data memory. Operands are never named: a load operation copies a memory word onto the top of an eight-entry register stack, an add combines the two uppermost entries into one, and a store operation removes the top entry and writes it to a memory word. A result reaches memory only through an explicit store, so the sequence load 10, load 11, add, store 12 with words 2 and 3 leaves 5 in word 12.

Each operation is launched by a one-cycle start strobe with an opcode and a memory address. The block answers with a busy cycle and then a one-cycle done pulse. The current top value, the stack depth and two sticky error flags are visible at all times. The data memory has a separate host port: a write port for preloading words and a combinational read port for inspecting them.

Top module: `stk_datapath`

## Requirements
- R1: A synchronous active-high reset empties the stack (depth 0, top value 0), clears both error flags, clears every memory word and leaves busy and done low.
- R2: A start strobe seen while idle is accepted on that clock edge; busy is high for exactly the next cycle, the operation takes effect on the following edge, done is high for exactly one cycle after that edge while busy is low, and a start seen while busy is ignored.
- R3: Opcode 0 (load) copies memory word addr onto the top of the stack, moves every existing entry one place down, and raises depth by one.
- R4: Opcode 2 (add) replaces the two uppermost entries with their sum modulo 2^16 as the new top and lowers depth by one.
- R5: Opcode 1 (store) writes the top value to memory word addr, removes it so the second entry becomes the top, and lowers depth by one; an empty stack shows a top value of 0.
- R6: A load while depth is 8 sets the overflow flag and changes neither the stack nor the depth.
- R7: An add with fewer than two entries, or a store on an empty stack, sets the underflow flag and changes neither the stack, the depth nor any memory word.
- R8: Opcode 3 completes with the normal busy and done timing and changes no state.
- R9: When a host write and a store write hit the same memory word on the same edge, the store value is kept; a load that executes on the same edge as a host write to its address takes the value held before that edge.
- R10: A host write stores its data on the clock edge where it is enabled, and the peek port shows the addressed word combinationally.
- R11: Once set, the overflow and underflow flags stay set through later valid operations until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, sampled while idle |
| op | input | 2 | Opcode: 0 load, 1 store, 2 add, 3 no-op |
| addr | input | 4 | Memory word used by load or store |
| busy | output | 1 | High while an accepted operation is pending |
| done | output | 1 | One-cycle completion pulse |
| tos | output | 16 | Current top-of-stack value |
| depth | output | 4 | Number of occupied stack entries, 0 to 8 |
| ovf | output | 1 | Sticky overflow flag |
| udf | output | 1 | Sticky underflow flag |
| ld_en | input | 1 | Host write enable for the data memory |
| ld_addr | input | 4 | Host write address |
| ld_data | input | 16 | Host write data |
| pk_addr | input | 4 | Peek read address |
| pk_data | output | 16 | Memory word at pk_addr |

## Verification
The memory has two writers, the host port and the store operation, and a store or load can execute on the very edge a host write lands on the same word. The bench provokes this by raising the host write enable during the busy cycle of a store or load aimed at the same address, so both take effect on the execute edge. For the store it judges through the peek port that the stored stack value, not the host data, remains; for the load it judges that the top value is the old word while the peek port shows the new host data.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int STK_DW    = 16;
    localparam int STK_DEPTH = 8;
    localparam int STK_AW    = 4;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_ADD   = 2'd2,
        OP_NOP   = 2'd3
    } stk_op_e;

    typedef enum logic [1:0] {
        SC_HOLD  = 2'd0,
        SC_PUSH  = 2'd1,
        SC_DROP  = 2'd2,
        SC_SUM   = 2'd3
    } stk_cmd_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } stk_fsm_e;

    typedef struct packed {
        stk_op_e                op;
        logic [STK_AW-1:0]      addr;
    } stk_req_t;

    function automatic logic [STK_DW-1:0] wrap_add(input logic [STK_DW-1:0] a,
                                                   input logic [STK_DW-1:0] b);
        return a + b;
    endfunction

endpackage

// File: rtl/stk_mem.sv
module stk_mem
    import stk_pkg::*;
#(
    parameter int DW = STK_DW,
    parameter int AW = STK_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          st_we,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          hb_we,
    input  logic [AW-1:0] hb_addr,
    input  logic [DW-1:0] hb_data,
    input  logic [AW-1:0] pk_addr,
    output logic [DW-1:0] pk_data
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] words_q [WORDS];

    // stack write is applied last so it wins on a shared address
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) words_q[i] <= '0;
        end else begin
            if (hb_we) words_q[hb_addr] <= hb_data;
            if (st_we) words_q[st_addr] <= st_data;
        end
    end

    assign rd_data = words_q[rd_addr];
    assign pk_data = words_q[pk_addr];

    // R9 / R5: a stack write is what the word holds afterwards
    a_r9_store_wins: assert property (@(posedge clk) disable iff (rst)
        st_we |=> words_q[$past(st_addr)] == $past(st_data));

    // R10: a lone host write lands
    a_r10_host_write: assert property (@(posedge clk) disable iff (rst)
        (hb_we && !(st_we && st_addr == hb_addr)) |=> words_q[$past(hb_addr)] == $past(hb_data));

endmodule

// File: rtl/stk_regs.sv
module stk_regs
    import stk_pkg::*;
#(
    parameter int DW    = STK_DW,
    parameter int DEPTH = STK_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  stk_cmd_e      cmd,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] top
);
    logic [DW-1:0] ent_q [DEPTH];
    logic [DW-1:0] ent_d [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_ent
            if (g == 0) begin : g_top
                always_comb begin
                    unique case (cmd)
                        SC_PUSH: ent_d[g] = din;
                        SC_DROP: ent_d[g] = ent_q[1];
                        SC_SUM:  ent_d[g] = wrap_add(ent_q[0], ent_q[1]);
                        default: ent_d[g] = ent_q[g];
                    endcase
                end
            end else if (g == DEPTH - 1) begin : g_bottom
                always_comb begin
                    unique case (cmd)
                        SC_PUSH: ent_d[g] = ent_q[g-1];
                        SC_DROP,
                        SC_SUM:  ent_d[g] = '0;
                        default: ent_d[g] = ent_q[g];
                    endcase
                end
            end else begin : g_mid
                always_comb begin
                    unique case (cmd)
                        SC_PUSH: ent_d[g] = ent_q[g-1];
                        SC_DROP,
                        SC_SUM:  ent_d[g] = ent_q[g+1];
                        default: ent_d[g] = ent_q[g];
                    endcase
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
        end
    end

    assign top = ent_q[0];

    a_r3_push_top: assert property (@(posedge clk) disable iff (rst)
        cmd == SC_PUSH |=> top == $past(din) && ent_q[1] == $past(ent_q[0]));

    a_r4_sum_top: assert property (@(posedge clk) disable iff (rst)
        cmd == SC_SUM |=> top == $past(ent_q[0]) + $past(ent_q[1]));

    a_r5_drop_shift: assert property (@(posedge clk) disable iff (rst)
        cmd == SC_DROP |=> top == $past(ent_q[1]));

    a_r8_hold_still: assert property (@(posedge clk) disable iff (rst)
        cmd == SC_HOLD |=> $stable(top));

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int DEPTH = STK_DEPTH,
    parameter int AW    = STK_AW,
    localparam int DPW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  stk_op_e        op,
    input  logic [AW-1:0]  addr,
    output logic           busy,
    output logic           done,
    output logic [DPW-1:0] depth,
    output logic           ovf,
    output logic           udf,
    output stk_cmd_e       cmd,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr
);
    localparam logic [DPW-1:0] FULL = DPW'(DEPTH);

    stk_fsm_e       state_q;
    stk_req_t       req_q;
    logic [DPW-1:0] depth_q, depth_d;
    logic           ovf_q, udf_q, set_ovf, set_udf, done_q;
    logic           exec;

    assign exec = (state_q == ST_EXEC);

    always_comb begin
        cmd     = SC_HOLD;
        mem_we  = 1'b0;
        depth_d = depth_q;
        set_ovf = 1'b0;
        set_udf = 1'b0;
        if (exec) begin
            unique case (req_q.op)
                OP_LOAD: begin
                    if (depth_q == FULL) set_ovf = 1'b1;
                    else begin
                        cmd     = SC_PUSH;
                        depth_d = depth_q + 1'b1;
                    end
                end
                OP_STORE: begin
                    if (depth_q == '0) set_udf = 1'b1;
                    else begin
                        cmd     = SC_DROP;
                        mem_we  = 1'b1;
                        depth_d = depth_q - 1'b1;
                    end
                end
                OP_ADD: begin
                    if (depth_q < DPW'(2)) set_udf = 1'b1;
                    else begin
                        cmd     = SC_SUM;
                        depth_d = depth_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            depth_q <= '0;
            ovf_q   <= 1'b0;
            udf_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q  <= exec;
            depth_q <= depth_d;
            ovf_q   <= ovf_q | set_ovf;
            udf_q   <= udf_q | set_udf;
            if (exec) begin
                state_q <= ST_IDLE;
            end else if (start) begin
                state_q  <= ST_EXEC;
                req_q.op <= op;
                req_q.addr <= addr;
            end
        end
    end

    assign busy     = exec;
    assign done     = done_q;
    assign depth    = depth_q;
    assign ovf      = ovf_q;
    assign udf      = udf_q;
    assign mem_addr = req_q.addr;

    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r2_busy_single: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy && done);

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_full_hold: assert property (@(posedge clk) disable iff (rst)
        (exec && req_q.op == OP_LOAD && depth_q == FULL) |=> depth == FULL && ovf);

    a_r7_empty_store: assert property (@(posedge clk) disable iff (rst)
        (exec && req_q.op == OP_STORE && depth_q == '0) |=> depth == '0 && udf);

    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    a_r11_udf_sticky: assert property (@(posedge clk) disable iff (rst)
        udf |=> udf);

    a_r1_depth_bound: assert property (@(posedge clk) disable iff (rst)
        depth <= FULL);

endmodule

// File: rtl/stk_datapath.sv
module stk_datapath
    import stk_pkg::*;
#(
    parameter int DW    = STK_DW,
    parameter int DEPTH = STK_DEPTH,
    parameter int AW    = STK_AW,
    localparam int DPW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [1:0]     op,
    input  logic [AW-1:0]  addr,
    output logic           busy,
    output logic           done,
    output logic [DW-1:0]  tos,
    output logic [DPW-1:0] depth,
    output logic           ovf,
    output logic           udf,
    input  logic           ld_en,
    input  logic [AW-1:0]  ld_addr,
    input  logic [DW-1:0]  ld_data,
    input  logic [AW-1:0]  pk_addr,
    output logic [DW-1:0]  pk_data
);
    stk_cmd_e      cmd;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rd;
    logic [DW-1:0] top;

    stk_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .op       (stk_op_e'(op)),
        .addr     (addr),
        .busy     (busy),
        .done     (done),
        .depth    (depth),
        .ovf      (ovf),
        .udf      (udf),
        .cmd      (cmd),
        .mem_we   (mem_we),
        .mem_addr (mem_addr)
    );

    stk_regs #(.DW(DW), .DEPTH(DEPTH)) u_regs (
        .clk (clk),
        .rst (rst),
        .cmd (cmd),
        .din (mem_rd),
        .top (top)
    );

    stk_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .st_we   (mem_we),
        .st_addr (mem_addr),
        .st_data (top),
        .rd_addr (mem_addr),
        .rd_data (mem_rd),
        .hb_we   (ld_en),
        .hb_addr (ld_addr),
        .hb_data (ld_data),
        .pk_addr (pk_addr),
        .pk_data (pk_data)
    );

    assign tos = top;

    // R5: an empty stack never shows a stale value on top
    a_r5_empty_zero: assert property (@(posedge clk) disable iff (rst)
        depth == '0 |-> tos == '0);

endmodule

// File: tb/test_stk_datapath.sv
module test_stk_datapath;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd3;
    logic [3:0]  addr = '0;
    logic        busy, done, ovf, udf;
    logic [15:0] tos;
    logic [3:0]  depth;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [3:0]  pk_addr = '0;
    logic [15:0] pk_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] m_stk [8];
    int          m_depth;
    bit          m_ovf, m_udf;
    logic [15:0] m_mem [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    stk_datapath i_stk_datapath (
        .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr),
        .busy(busy), .done(done), .tos(tos), .depth(depth),
        .ovf(ovf), .udf(udf), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .pk_addr(pk_addr), .pk_data(pk_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic [15:0] m_top();
        return (m_depth == 0) ? 16'h0 : m_stk[0];
    endfunction

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
        m_depth = 0; m_ovf = 0; m_udf = 0;
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
    endtask

    task automatic check_state(input string req);
        chk(tos == m_top(), {req, " tos"}, tos, m_top());
        chk(depth == 4'(m_depth), {req, " depth"}, depth, m_depth);
        chk(ovf == m_ovf && udf == m_udf, {req, " flags"}, {ovf, udf}, {m_ovf, m_udf});
    endtask

    task automatic host_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk) ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk) ld_en = 1'b0;
        m_mem[a] = d;
    endtask

    task automatic peek(input logic [3:0] a, input string req);
        pk_addr = a;
        #1;
        chk(pk_data == m_mem[a], req, pk_data, m_mem[a]);
    endtask

    // cl: host write to the same address during the busy cycle
    // hold: keep start high through the busy cycle
    task automatic run_op(input logic [1:0] o, input logic [3:0] a,
                          input bit cl, input logic [15:0] cl_d, input bit hold);
        string tag;
        logic [15:0] popped;
        @(negedge clk) start = 1'b1; op = o; addr = a;
        @(negedge clk);
        chk(busy == 1'b1 && done == 1'b0, "R2 busy after accept", {busy, done}, 2'b10);
        if (!hold) start = 1'b0;
        else begin op = 2'd0; addr = a + 4'd1; end
        if (cl) begin ld_en = 1'b1; ld_addr = a; ld_data = cl_d; end
        // reference model
        case (o)
            2'd0: begin
                tag = "R3 load";
                if (m_depth == 8) begin m_ovf = 1; tag = "R6 overflow"; end
                else begin
                    for (int i = 7; i > 0; i--) m_stk[i] = m_stk[i-1];
                    m_stk[0] = m_mem[a];
                    m_depth++;
                end
                if (cl) m_mem[a] = cl_d;
            end
            2'd1: begin
                tag = "R5 store";
                if (cl) m_mem[a] = cl_d;
                if (m_depth == 0) begin m_udf = 1; tag = "R7 store empty"; end
                else begin
                    popped = m_stk[0];
                    for (int i = 0; i < 7; i++) m_stk[i] = m_stk[i+1];
                    m_stk[7] = '0;
                    m_depth--;
                    m_mem[a] = popped;
                end
            end
            2'd2: begin
                tag = "R4 add";
                if (m_depth < 2) begin m_udf = 1; tag = "R7 add short"; end
                else begin
                    m_stk[0] = m_stk[0] + m_stk[1];
                    for (int i = 1; i < 7; i++) m_stk[i] = m_stk[i+1];
                    m_stk[7] = '0;
                    m_depth--;
                end
            end
            default: begin
                tag = "R8 nop";
                if (cl) m_mem[a] = cl_d;
            end
        endcase
        @(negedge clk);
        start = 1'b0;
        ld_en = 1'b0;
        chk(done == 1'b1 && busy == 1'b0, "R2 done pulse", {busy, done}, 2'b01);
        check_state(tag);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R2 done drops", {busy, done}, 2'b00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] va, vb;
        do_reset();
        // R1 reset state
        chk(tos == 0 && depth == 0, "R1 reset stack", {tos, depth}, 0);
        chk(!ovf && !udf && !busy && !done, "R1 reset flags", {ovf, udf, busy, done}, 0);

        // R10 preload sweep and peek
        for (int i = 0; i < 16; i++) host_write(4'(i), 16'((i * 16'h1357) ^ 16'hF00F));
        for (int i = 0; i < 16; i++) peek(4'(i), "R10 peek");

        // worked example: 2 + 3 -> word 12 (R3 R4 R5)
        host_write(4'd10, 16'd2);
        host_write(4'd11, 16'd3);
        run_op(2'd0, 4'd10, 0, 0, 0);
        run_op(2'd0, 4'd11, 0, 0, 0);
        run_op(2'd2, 4'd0, 0, 0, 0);
        run_op(2'd1, 4'd12, 0, 0, 0);
        peek(4'd12, "R5 example sum stored");
        chk(pk_data == 16'd5, "R5 example value", pk_data, 5);

        // R7 underflow on empty stack, memory untouched
        run_op(2'd1, 4'd3, 0, 0, 0);
        peek(4'd3, "R7 no memory write");
        run_op(2'd0, 4'd4, 0, 0, 0);
        run_op(2'd2, 4'd0, 0, 0, 0);
        // R11 flag survives valid ops
        run_op(2'd1, 4'd5, 0, 0, 0);
        chk(udf == 1'b1, "R11 udf sticky", udf, 1);

        // R1 reset clears flags and memory
        do_reset();
        check_state("R1 after reset");
        peek(4'd12, "R1 memory cleared");

        // fill sweep: 8 loads, then overflow (R3 R6)
        for (int i = 0; i < 16; i++) host_write(4'(i), 16'(16'hFF00 + i * 16'h0131));
        for (int i = 0; i < 8; i++) run_op(2'd0, 4'((i * 3) & 15), 0, 0, 0);
        run_op(2'd0, 4'd9, 0, 0, 0);
        chk(ovf == 1'b1, "R6 ovf set", ovf, 1);
        // R4 wrap through repeated adds down to one entry
        for (int i = 0; i < 7; i++) run_op(2'd2, 4'd0, 0, 0, 0);
        run_op(2'd2, 4'd0, 0, 0, 0);
        // R8 nop on a nonempty stack
        run_op(2'd3, 4'd7, 0, 0, 0);
        run_op(2'd1, 4'd15, 0, 0, 0);
        peek(4'd15, "R5 sum stored");
        chk(ovf == 1'b1, "R11 ovf sticky", ovf, 1);

        // R4 pair sweep with arithmetic operands
        do_reset();
        for (int k = 0; k < 24; k++) begin
            va = 16'(16'hF000 + k * 16'h0AF3);
            vb = 16'(k * 16'h2D11 + 16'h1FFF);
            host_write(4'd0, va);
            host_write(4'd1, vb);
            run_op(2'd0, 4'd0, 0, 0, 0);
            run_op(2'd0, 4'd1, 0, 0, 0);
            run_op(2'd2, 4'd0, 0, 0, 0);
            run_op(2'd1, 4'(2 + (k % 14)), 0, 0, 0);
            peek(4'(2 + (k % 14)), "R4 wrapped sum");
            chk(pk_data == 16'(va + vb), "R4 sum value", pk_data, 16'(va + vb));
        end

        // R9 concurrent writers
        host_write(4'd6, 16'h1234);
        run_op(2'd0, 4'd6, 1, 16'hBEEF, 0);
        peek(4'd6, "R9 host write beside load");
        chk(tos == 16'h1234, "R9 load sees old word", tos, 16'h1234);
        run_op(2'd1, 4'd8, 1, 16'hDEAD, 0);
        peek(4'd8, "R9 store wins");
        chk(pk_data == 16'h1234, "R9 store value kept", pk_data, 16'h1234);

        // R2 start held during busy is ignored
        host_write(4'd2, 16'h0042);
        run_op(2'd0, 4'd2, 0, 0, 1);
        @(negedge clk);
        chk(busy == 1'b0 && depth == 4'd1, "R2 held start ignored", {busy, depth}, 1);

        finish_run();
    end

endmodule